// File: doc/BRIEF.md
# Programmable Frequency Generator Channel

One channel of a clock frequency generator that runs entirely in a single fast system clock domain. Up to three PLL-derived sources are represented as enable strobes (one cycle wide, one strobe per source period). The channel picks one of them, counts its strobes against a divisor taken from a 10-bit control field, and produces two outputs: a square wave and a one-strobe-per-period tick.

A parameter selects one of two control layouts. The legacy layout has a one-bit source select, a separate enable bit and a divisor that is always even. The extended layout folds the disabled state into a two-bit source code and adds a scale input. With scale set, the divisor may be any integer. The channel remembers the last non-zero source code, so an enable request restores it and a disable request parks the code at zero. Writes to the field, enable and disable requests, and changes of scale all restart the divided period.

Top module: `freq_gen_channel`

## Requirements
- R1: Legacy layout (EXTENDED=0): field bit 0 selects the source (0 = src_tick[0], 1 = src_tick[1]), bit 1 is the enable, bits 9:2 hold N, and the divisor is (N+1)*2 whatever the scale input is.
- R2: Extended layout (EXTENDED=1): field bits 1:0 are a source code. Code 0 is disabled, code 1 selects src_tick[2], code 2 selects src_tick[0] and code 3 selects src_tick[1]. Bits 9:2 hold N.
- R3: In the extended layout the divisor D is N+1 when scale is 1 and (N+1)*2 when scale is 0. A scale change takes effect one clock after it is applied.
- R4: For D > 1, counting from the start of a period, out_sq is high during the first ceil(D/2) selected strobes and low during the rest. This gives an exact 50% duty cycle for even D, and a high phase one strobe longer than the low phase for odd D. out_tick is high together with the strobe that closes each period.
- R5: When D = 1, out_sq and out_tick both equal the selected source strobe.
- R6: A field write, an enable request, a disable request or a change of scale each restarts the period from count zero on the next clock.
- R7: While the channel is disabled, out_sq and out_tick are low and the divider count is held at zero.
- R8: Extended layout: en_req writes the remembered source code into bits 1:0, and dis_req writes code 0. A field write with a non-zero code updates the remembered code. A field write with code 0 disables the channel and leaves the remembered code unchanged.
- R9: Reset loads field_q with RESET_FIELD (default 0). In the extended layout a reset code of 0 sets the remembered code to 1 and leaves the channel disabled.
- R10: Legacy layout: en_req sets bit 1 and dis_req clears bit 1. All other field bits are left unchanged.
- R11: is_en reflects bit 1 in the legacy layout and a non-zero source code in the extended layout.
- R12: When requests arrive in the same clock, wr_en takes precedence over en_req, and en_req takes precedence over dis_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 3 | Source strobes |
| scale | input | 1 | Fine-divisor select (extended layout only) |
| wr_en | input | 1 | Write wr_data into the control field |
| wr_data | input | DIV_W+2 | Control field write value |
| en_req | input | 1 | Enable request |
| dis_req | input | 1 | Disable request |
| field_q | output | DIV_W+2 | Current control field |
| is_en | output | 1 | Channel enabled status |
| out_tick | output | 1 | One strobe per divided period |
| out_sq | output | 1 | Divided square wave |

## Verification
The hardest state to reach from the ports is a restart in the middle of a period. The bench starts a long period with every source strobing on each clock, lets it run part of the way, then writes a shorter divisor. It then checks that the new waveform begins at count zero on the first sample after the write. The other case that needs care is the remembered source code: the bench writes code 0 while carrying a new N, and then confirms that an enable request brings back the earlier non-zero code together with that N.

// File: rtl/freq_gen_channel.sv
module freq_gen_channel #(
  parameter bit EXTENDED = 1'b1,
  parameter int DIV_W = 8,
  parameter logic [DIV_W+1:0] RESET_FIELD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_tick,
  input  logic             scale,
  input  logic             wr_en,
  input  logic [DIV_W+1:0] wr_data,
  input  logic             en_req,
  input  logic             dis_req,
  output logic [DIV_W+1:0] field_q,
  output logic             is_en,
  output logic             out_tick,
  output logic             out_sq
);
  localparam int FW = DIV_W + 2;
  localparam int CW = DIV_W + 1;
  localparam int DW = DIV_W + 2;
  localparam logic [1:0] RST_MEM = (RESET_FIELD[1:0] == 2'd0) ? 2'd1 : RESET_FIELD[1:0];

  logic [1:0]    mem;
  logic          scale_q;
  logic [CW-1:0] cnt;
  logic          sel_tick;
  logic [DW-1:0] div;
  logic [DW-1:0] hi_len;
  logic          last;
  logic          reload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= RESET_FIELD;
      mem     <= RST_MEM;
    end else if (wr_en) begin
      field_q <= wr_data;
      if (wr_data[1:0] != 2'd0) mem <= wr_data[1:0];
    end else if (en_req) begin
      if (EXTENDED) field_q[1:0] <= mem;
      else          field_q[1]   <= 1'b1;
    end else if (dis_req) begin
      if (EXTENDED) field_q[1:0] <= 2'd0;
      else          field_q[1]   <= 1'b0;
    end
  end

  generate
    if (EXTENDED) begin : g_ext
      assign is_en = field_q[1:0] != 2'd0;
      always_comb begin
        case (field_q[1:0])
          2'd1:    sel_tick = src_tick[2];
          2'd2:    sel_tick = src_tick[0];
          2'd3:    sel_tick = src_tick[1];
          default: sel_tick = 1'b0;
        endcase
      end
      assign div = scale_q ? {1'b0, {1'b0, field_q[FW-1:2]} + CW'(1)}
                           : {{1'b0, field_q[FW-1:2]} + CW'(1), 1'b0};
    end else begin : g_leg
      assign is_en    = field_q[1];
      assign sel_tick = field_q[0] ? src_tick[1] : src_tick[0];
      assign div      = {{1'b0, field_q[FW-1:2]} + CW'(1), 1'b0};
    end
  endgenerate

  assign hi_len   = (div + DW'(1)) >> 1;
  assign last     = {1'b0, cnt} == div - DW'(1);
  assign reload   = wr_en | en_req | dis_req | (scale != scale_q);
  assign out_tick = is_en & sel_tick & last;
  assign out_sq   = is_en & ((div == DW'(1)) ? sel_tick : ({1'b0, cnt} < hi_len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q <= 1'b0;
      cnt     <= '0;
    end else begin
      scale_q <= scale;
      if (!is_en || reload) cnt <= '0;
      else if (sel_tick)    cnt <= last ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/freq_gen_channel_chk.sv
module freq_gen_channel_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          is_en,
  input logic          out_sq,
  input logic          out_tick,
  input logic          wr_en,
  input logic          en_req,
  input logic          dis_req,
  input logic [CW-1:0] cnt
);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !is_en |-> (!out_sq && !out_tick));
  a_r7_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    !is_en |=> cnt == '0);
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || en_req || dis_req) |=> cnt == '0);
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |=> cnt == '0);
  a_r12_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && !wr_en) |=> is_en);
  a_r12_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_req && !wr_en && !en_req) |=> !is_en);
endmodule

bind freq_gen_channel freq_gen_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_en(is_en), .out_sq(out_sq), .out_tick(out_tick),
  .wr_en(wr_en), .en_req(en_req), .dis_req(dis_req), .cnt(cnt)
);

// File: tb/freq_gen_channel_bench.sv
module freq_gen_channel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] src_x = '0, src_l = '0;
  logic scale_x = 1'b0, scale_l = 1'b0;
  logic wr_x = 1'b0, wr_l = 1'b0, en_x = 1'b0, en_l = 1'b0, dis_x = 1'b0, dis_l = 1'b0;
  logic [9:0] wd_x = '0, wd_l = '0;
  logic [9:0] fq_x, fq_l;
  logic ie_x, ie_l, tk_x, tk_l, sq_x, sq_l;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  freq_gen_channel #(.EXTENDED(1'b1)) u_freq_gen_channel (
    .clk(clk), .rst_n(rst_n), .src_tick(src_x), .scale(scale_x), .wr_en(wr_x),
    .wr_data(wd_x), .en_req(en_x), .dis_req(dis_x), .field_q(fq_x), .is_en(ie_x),
    .out_tick(tk_x), .out_sq(sq_x));

  freq_gen_channel #(.EXTENDED(1'b0)) u_freq_gen_channel_legacy (
    .clk(clk), .rst_n(rst_n), .src_tick(src_l), .scale(scale_l), .wr_en(wr_l),
    .wr_data(wd_l), .en_req(en_l), .dis_req(dis_l), .field_q(fq_l), .is_en(ie_l),
    .out_tick(tk_l), .out_sq(sq_l));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit leg, input logic [9:0] d);
    @(negedge clk);
    if (leg) begin wr_l = 1'b1; wd_l = d; end else begin wr_x = 1'b1; wd_x = d; end
    @(negedge clk);
    wr_l = 1'b0; wr_x = 1'b0;
  endtask

  task automatic req(input bit leg, input bit en, input bit dis);
    @(negedge clk);
    if (leg) begin en_l = en; dis_l = dis; end else begin en_x = en; dis_x = dis; end
    @(negedge clk);
    en_l = 1'b0; dis_l = 1'b0; en_x = 1'b0; dis_x = 1'b0;
  endtask

  task automatic pat(input bit leg, input int d, input string reqn);
    int errs = 0;
    int fa = 0, fe = 0;
    for (int k = 0; k < 2 * d; k++) begin
      int ph = k % d;
      int es = (d == 1) ? 1 : ((ph < (d + 1) / 2) ? 1 : 0);
      int et = (ph == d - 1) ? 1 : 0;
      int as = leg ? int'(sq_l) : int'(sq_x);
      int at = leg ? int'(tk_l) : int'(tk_x);
      if ((as != es || at != et) && errs == 0) begin fa = as * 2 + at; fe = es * 2 + et; end
      if (as != es || at != et) errs++;
      if (k < 2 * d - 1) @(negedge clk);
    end
    check(reqn, $sformatf("waveform D=%0d {sq,tick}", d), fa, fe);
  endtask

  task automatic count_ticks(input bit leg, input int cyc, output int n);
    n = 0;
    for (int k = 0; k < cyc; k++) begin
      n += leg ? int'(tk_l) : int'(tk_x);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R9", "ext field after reset", int'(fq_x), 0);
    check("R11", "ext is_en after reset", int'(ie_x), 0);
    check("R7", "ext out_sq after reset", int'(sq_x), 0);
    check("R9", "legacy field after reset", int'(fq_l), 0);
    req(1'b0, 1'b1, 1'b0);
    check("R9", "default remembered code", int'(fq_x[1:0]), 1);
    check("R11", "ext is_en after enable", int'(ie_x), 1);
  endtask

  task automatic t_ext_divide();
    src_x = 3'b111;
    scale_x = 1'b1;
    @(negedge clk);
    wr(1'b0, {8'd2, 2'd2});
    pat(1'b0, 3, "R3 R4 odd");
    wr(1'b0, {8'd3, 2'd2});
    pat(1'b0, 4, "R4 even");
    wr(1'b0, {8'd0, 2'd2});
    pat(1'b0, 1, "R5");
    src_x = 3'b110;
    #1;
    check("R5", "D=1 follows idle strobe", int'(sq_x), 0);
    src_x = 3'b111;
    @(negedge clk);
    scale_x = 1'b0;
    @(negedge clk);
    pat(1'b0, 2, "R3 R6 scale clear");
    wr(1'b0, {8'd255, 2'd2});
    pat(1'b0, 512, "R3 max");
  endtask

  task automatic t_ext_select();
    int n;
    scale_x = 1'b1;
    @(negedge clk);
    src_x = 3'b100;
    wr(1'b0, {8'd1, 2'd1});
    count_ticks(1'b0, 8, n); check("R2", "code1 on src2", n, 4);
    wr(1'b0, {8'd1, 2'd2});
    count_ticks(1'b0, 8, n); check("R2", "code2 blind to src2", n, 0);
    src_x = 3'b001;
    wr(1'b0, {8'd1, 2'd2});
    count_ticks(1'b0, 8, n); check("R2", "code2 on src0", n, 4);
    src_x = 3'b010;
    wr(1'b0, {8'd1, 2'd3});
    count_ticks(1'b0, 8, n); check("R2", "code3 on src1", n, 4);
  endtask

  task automatic t_ext_memory();
    int hi = 0;
    src_x = 3'b111;
    wr(1'b0, {8'd1, 2'd3});
    req(1'b0, 1'b0, 1'b1);
    check("R8", "code after disable", int'(fq_x[1:0]), 0);
    for (int k = 0; k < 6; k++) begin hi += int'(sq_x) + int'(tk_x); @(negedge clk); end
    check("R7", "outputs while disabled", hi, 0);
    req(1'b0, 1'b1, 1'b0);
    check("R8", "code restored", int'(fq_x[1:0]), 3);
    wr(1'b0, {8'd5, 2'd0});
    check("R11", "code0 write disables", int'(ie_x), 0);
    req(1'b0, 1'b1, 1'b0);
    check("R8", "code0 write keeps memory", int'(fq_x), int'({8'd5, 2'd3}));
  endtask

  task automatic t_reload();
    src_x = 3'b111;
    scale_x = 1'b1;
    @(negedge clk);
    wr(1'b0, {8'd7, 2'd2});
    repeat (3) @(negedge clk);
    wr(1'b0, {8'd3, 2'd2});
    pat(1'b0, 4, "R6 mid-period write");
  endtask

  task automatic t_priority();
    @(negedge clk);
    wr_x = 1'b1; wd_x = {8'd1, 2'd1}; dis_x = 1'b1;
    @(negedge clk);
    wr_x = 1'b0; dis_x = 1'b0;
    check("R12", "write beats disable", int'(fq_x[1:0]), 1);
    @(negedge clk);
    en_x = 1'b1; dis_x = 1'b1;
    @(negedge clk);
    en_x = 1'b0; dis_x = 1'b0;
    check("R12", "enable beats disable", int'(ie_x), 1);
  endtask

  task automatic t_legacy();
    int n;
    src_l = 3'b111;
    scale_l = 1'b1;
    @(negedge clk);
    wr(1'b1, {8'd1, 2'b10});
    pat(1'b1, 4, "R1 even, scale ignored");
    src_l = 3'b010;
    wr(1'b1, {8'd1, 2'b10});
    count_ticks(1'b1, 8, n); check("R1", "select 0 blind to src1", n, 0);
    wr(1'b1, {8'd1, 2'b11});
    count_ticks(1'b1, 8, n); check("R1", "select 1 on src1", n, 2);
    req(1'b1, 1'b0, 1'b1);
    check("R10", "field after disable", int'(fq_l), int'({8'd1, 2'b01}));
    check("R11", "legacy is_en after disable", int'(ie_l), 0);
    req(1'b1, 1'b1, 1'b0);
    check("R10", "field after enable", int'(fq_l), int'({8'd1, 2'b11}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext_divide();
    t_ext_select();
    t_ext_memory();
    t_reload();
    t_priority();
    t_legacy();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule